// File: doc/BRIEF.md
# Ultra DMA Device Burst Interface

This block implements the device end of a synchronous IDE data path while the card runs in its disk-compatible mode. The block handles two burst directions. When the host writes, each level change of the host strobe carries one 16-bit word. The block resynchronises the strobe into the system clock and detects every change. It then hands each captured word to an internal buffer through a valid/ready stream. When the host reads, the block takes words from a second valid/ready stream and drives them onto the data bus. Each sent word flips the device strobe. Words move only while the host's active-low ready line is low.

A burst starts when DMA acknowledge goes low. The direction is taken from `dir_in` at that moment. The host ends a burst with its stop line. The block then waits in a terminating phase until any captured word has been taken by the buffer and acknowledge has been released. The block flags two conditions. It flags a register chip select that is asserted while acknowledge is low, and it flags a word that arrives while the buffer is still holding the previous one. A per-burst word counter stays readable after the burst ends.

Top module: `udma_burst_dev`

## Requirements
- R1: In a write burst (`phase` = 1), every rising and every falling change of `host_line` delivers exactly one `host_data` word on `rx_data` with `rx_valid` high, in arrival order, and adds one to `word_count`.
- R2: A gap of any length between strobe changes loses and repeats no word; the burst resumes on the next change.
- R3: In a read burst (`phase` = 2), `tx_ready` is never high unless `host_line` (ready, active low) was low at the edge two clocks earlier. Each accepted word appears on `dev_data` with a flip of `dev_strobe`, and `word_count` counts it.
- R4: A high `host_stop` during a burst moves `phase` to 3. `phase` returns to 0 only once `dmack_n` is high.
- R5: `prot_err` rises one clock after `cs0_n` or `cs1_n` is low while `dmack_n` is low. It stays set until the next burst starts.
- R6: While `host_stop` is high, a low `dmack_n` does not start a burst (`phase` stays 0).
- R7: `word_count` is cleared when a burst starts and holds its final value after the burst ends.
- R8: A strobe change that finds `rx_valid` high and `rx_ready` low sets `overflow` for the rest of the burst. That word is not counted, and the held word is kept unchanged.
- R9: `phase` stays 3 while a captured word is still waiting on `rx_valid`.
- R10: After reset, `phase` is 0 and `rx_valid`, `dev_oe`, `overflow`, `prot_err` and `word_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dmack_n | input | 1 | DMA acknowledge from host, active low |
| cs0_n | input | 1 | Command register select, active low |
| cs1_n | input | 1 | Control register select, active low |
| host_stop | input | 1 | Host request to end the burst, active high |
| dir_in | input | 1 | Burst direction latched at start: 1 = device to host |
| host_line | input | 1 | Host strobe in write bursts, host ready (active low) in read bursts |
| host_data | input | DW | Data bus from host |
| dev_data | output | DW | Data bus to host |
| dev_oe | output | 1 | Device drives the data bus |
| dev_strobe | output | 1 | Device strobe, flips once per sent word |
| rx_data | output | DW | Word toward the internal buffer |
| rx_valid | output | 1 | `rx_data` holds a word |
| rx_ready | input | 1 | Buffer accepts the word |
| tx_data | input | DW | Word from the internal buffer |
| tx_valid | input | 1 | `tx_data` holds a word |
| tx_ready | output | 1 | Device takes the word this clock |
| phase | output | 2 | 0 idle, 1 write burst, 2 read burst, 3 terminating |
| word_count | output | CW | Words moved in the current or last burst |
| overflow | output | 1 | A word arrived while the buffer was blocked |
| prot_err | output | 1 | A register select was asserted during acknowledge |

## Verification
Two pairs of events can fall in the same clock. A strobe change can arrive in the clock where the buffer is still holding the previous word. A stop request can arrive while a captured word has not been drained. The bench causes the first case by holding `rx_ready` low across two strobe changes. It then requires `overflow` to be set, the first word to be delivered intact and the count to grow by one only. For the second case, the bench stops the burst and releases acknowledge with the buffer still blocked. It requires the terminating phase to last until the pending word is taken. A behavioural model compares every stream handshake and every device strobe flip against queues on each clock.

// File: rtl/udma_burst_dev.sv
module udma_burst_dev #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dmack_n,
  input  logic          cs0_n,
  input  logic          cs1_n,
  input  logic          host_stop,
  input  logic          dir_in,
  input  logic          host_line,
  input  logic [DW-1:0] host_data,
  output logic [DW-1:0] dev_data,
  output logic          dev_oe,
  output logic          dev_strobe,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [1:0]    phase,
  output logic [CW-1:0] word_count,
  output logic          overflow,
  output logic          prot_err
);

  typedef enum logic [1:0] {IDLE = 2'd0, OUT_B = 2'd1, IN_B = 2'd2, TERM = 2'd3} st_t;
  st_t st;

  logic [2:0] hl_q;
  logic [1:0] stp_q;

  wire line_s  = hl_q[1];
  wire tog     = hl_q[1] ^ hl_q[2];
  wire stop_s  = stp_q[1];
  wire enter   = !dmack_n && !stop_s;
  wire end_req = stop_s || dmack_n;
  wire take    = (st == OUT_B) && tog && (!rx_valid || rx_ready);
  wire lost    = (st == OUT_B) && tog && rx_valid && !rx_ready;
  wire send    = tx_valid && tx_ready;
  wire cs_bad  = !dmack_n && (!cs0_n || !cs1_n);

  assign tx_ready = (st == IN_B) && !line_s && !stop_s && !dmack_n;
  assign dev_oe   = (st == IN_B);
  assign phase    = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q  <= '0;
      stp_q <= '0;
    end else begin
      hl_q  <= {hl_q[1:0], host_line};
      stp_q <= {stp_q[0], host_stop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      word_count <= '0;
      overflow   <= 1'b0;
    end else begin
      case (st)
        IDLE: if (enter) begin
          st         <= dir_in ? IN_B : OUT_B;
          word_count <= '0;
          overflow   <= 1'b0;
        end
        OUT_B: begin
          if (take) word_count <= word_count + 1'b1;
          if (lost) overflow <= 1'b1;
          if (end_req) st <= TERM;
        end
        IN_B: begin
          if (send) word_count <= word_count + 1'b1;
          if (end_req) st <= TERM;
        end
        default: if (!rx_valid && dmack_n) st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (take) begin
        rx_valid <= 1'b1;
        rx_data  <= host_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_data   <= '0;
      dev_strobe <= 1'b0;
    end else if (send) begin
      dev_data   <= tx_data;
      dev_strobe <= ~dev_strobe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_err <= 1'b0;
    else if (cs_bad) prot_err <= 1'b1;
    else if (st == IDLE && enter) prot_err <= 1'b0;
  end

  // R5
  perr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dmack_n && !cs0_n) |=> prot_err);

  // R6
  no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && stop_s) |=> (st == IDLE));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R3
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_strobe != $past(dev_strobe)) |-> ($past(st) == IN_B));

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TERM) |=> $stable(word_count));

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TERM && rx_valid) |=> (st == TERM));

endmodule

// File: tb/tb_udma_burst_dev.sv
`timescale 1ns/100ps
module tb_udma_burst_dev;
  logic clk = 0, rst_n = 0;
  logic dmack_n = 1, cs0_n = 1, cs1_n = 1, host_stop = 0, dir_in = 0, host_line = 0;
  logic [15:0] host_data = 0, dev_data, rx_data, tx_data;
  logic dev_oe, dev_strobe, rx_valid, rx_ready = 1, tx_valid = 0, tx_ready;
  logic [1:0] phase;
  logic [15:0] word_count;
  logic overflow, prot_err;

  int checks = 0, errors = 0, got_in = 0;
  logic [15:0] exp_q[$];
  logic [15:0] in_q[$];
  logic [1:0] hist = 0;
  logic last_strobe = 0;
  logic [15:0] tx_idx = 0;
  bit done = 0;

  assign tx_data = 16'hA000 + tx_idx;

  always #2.5 clk = ~clk;

  udma_burst_dev dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_word(input logic [15:0] w, input bit keep);
    @(posedge clk); #1;
    host_data = w;
    host_line = ~host_line;
    if (keep) exp_q.push_back(w);
    cyc(4);
  endtask

  always @(posedge clk) begin
    hist <= {hist[0], host_line};
    if (rst_n && tx_valid && tx_ready) tx_idx <= tx_idx + 1;
  end

  always @(negedge clk) if (rst_n) begin
    if (rx_valid && rx_ready) begin
      if (exp_q.size() == 0) chk(0, "R1 extra word", rx_data, 0);
      else begin
        logic [15:0] w;
        w = exp_q.pop_front();
        chk(rx_data == w, "R1 word order", rx_data, w);
      end
    end
    if (tx_ready && hist[1]) chk(0, "R3 ready gating", 1, 0);
    if (dev_strobe != last_strobe) begin
      last_strobe = dev_strobe;
      got_in++;
      if (in_q.size() == 0) chk(0, "R3 extra strobe", dev_data, 0);
      else begin
        logic [15:0] w;
        w = in_q.pop_front();
        chk(dev_data == w, "R3 sent word", dev_data, w);
      end
    end
    if (tx_valid && tx_ready) in_q.push_back(tx_data);
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R10 reset state
    chk(phase == 0, "R10 phase", phase, 0);
    chk(!rx_valid && !dev_oe, "R10 outputs", {rx_valid, dev_oe}, 0);
    chk(!overflow && !prot_err && word_count == 0, "R10 flags", word_count, 0);

    // R6 refused entry while stop held
    host_stop = 1; cyc(4);
    dmack_n = 0; cyc(6);
    chk(phase == 0, "R6 no entry", phase, 0);
    host_stop = 0; cyc(4);
    chk(phase == 1, "R6 entry after stop released", phase, 1);

    // R1 R2 write burst with a pause
    for (int i = 0; i < 4; i++) send_word(16'h1100 + 16'(i), 1);
    cyc(20);
    chk(word_count == 4, "R2 count held in pause", word_count, 4);
    for (int i = 0; i < 3; i++) send_word(16'h2200 + 16'(i), 1);
    cyc(6);
    chk(word_count == 7, "R1 both edges counted", word_count, 7);
    chk(exp_q.size() == 0, "R2 no loss", exp_q.size(), 0);
    chk(!overflow, "R8 no false overflow", overflow, 0);

    // R5 select during acknowledge
    cs0_n = 0; cyc(1); cs0_n = 1; cyc(1);
    chk(prot_err, "R5 prot_err set", prot_err, 1);

    // R8 overflow: buffer blocked across two strobe changes
    rx_ready = 0;
    send_word(16'h3300, 1);
    send_word(16'h3301, 0);
    cyc(4);
    chk(overflow, "R8 overflow flag", overflow, 1);
    chk(word_count == 8, "R8 lost word not counted", word_count, 8);
    chk(rx_valid && rx_data == 16'h3300, "R8 held word kept", rx_data, 16'h3300);

    // R4 R9 termination with pending word
    host_stop = 1; cyc(4);
    chk(phase == 3, "R4 stop ends burst", phase, 3);
    dmack_n = 1; cyc(4);
    chk(phase == 3, "R9 waits for drain", phase, 3);
    rx_ready = 1; cyc(4);
    chk(phase == 0, "R4 back to idle", phase, 0);
    chk(exp_q.size() == 0, "R9 pending word delivered", exp_q.size(), 0);
    chk(word_count == 8, "R7 count held after burst", word_count, 8);
    host_stop = 0; cyc(4);

    // R3 read burst gated by host ready
    dir_in = 1; host_line = 1; tx_valid = 1; cyc(4);
    dmack_n = 0; cyc(4);
    chk(phase == 2 && dev_oe, "R3 read burst entered", phase, 2);
    chk(!prot_err, "R5 cleared at burst start", prot_err, 0);
    chk(word_count == 0, "R7 cleared at start", word_count, 0);
    cyc(6);
    chk(got_in == 0, "R3 no words while not ready", got_in, 0);
    host_line = 0; cyc(10);
    host_line = 1; cyc(8);
    chk(got_in > 0, "R3 words flowed", got_in, 1);
    host_line = 0; cyc(5);
    host_stop = 1; cyc(4);
    chk(phase == 3, "R4 stop in read burst", phase, 3);
    cyc(2);
    chk(word_count == 16'(got_in), "R3 count matches host", word_count, got_in);
    chk(in_q.size() == 0, "R3 all accepted words sent", in_q.size(), 0);
    dmack_n = 1; cyc(3);
    chk(phase == 0, "R4 idle after read burst", phase, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule